// File: doc/BRIEF.md
# Big-Endian Load/Store Alignment Unit

This block sits between the memory stage of a 32-bit RISC pipeline and a data memory that is one word wide. For every request it adds the base register to the sign-extended 16-bit offset to form the effective address. It then issues a word-aligned memory address for that address. For stores it also issues byte-lane write strobes and the store data, copied into every lane of the access size. Lanes follow big-endian order, so address offset 0 is the most significant byte of the word.

For loads it records the access size, lane offset and signedness of the most recent accepted load. When the memory returns a word, the block picks out the byte, the halfword or the whole word and extends it to 32 bits. A halfword or word request that is not aligned to its size is never split into two accesses. The block raises a one-cycle misalign flag instead and issues neither a memory request nor any strobe. Requests go through one register stage, and load data also comes back through one register stage.

Top module: `be_lsu_align`

## Requirements
- R1: One cycle after a request is presented, `mem_addr` equals base plus the sign-extended 16-bit offset with its two low bits cleared. A negative offset therefore reaches addresses below the base.
- R2: `req_size` 00 selects a byte, 01 a halfword, and 10 or 11 a word. Strobe bit i covers `mem_wdata[8i+7:8i]`. A byte store at offset k sets strobe bit 3-k. A halfword store at offset 0 gives 1100 and at offset 2 gives 0011. A word store gives 1111.
- R3: Store data is copied into every lane of its size: the low byte four times, the low halfword twice, or the whole word.
- R4: A halfword request with address bit 0 set, or a word request with address bits 1:0 not 00, raises `misalign` for one cycle. In that cycle `mem_valid` is low and all strobes are 0.
- R5: An aligned load presents `mem_valid` high with `mem_write` low and all strobes 0.
- R6: `ld_valid` follows `rsp_valid` by one cycle. A byte load at offset k returns bits [31-8k:24-8k] of the returned word, and a halfword load at offset 0 or 2 returns bits [31:16] or [15:0].
- R7: With `req_unsigned` low, byte and halfword loads are sign-extended. With it high they are zero-extended. Word loads return the word unchanged either way.
- R8: The result of a load is formatted by the most recent aligned load request. Stores and misaligned requests issued after that load leave this formatting unchanged.
- R9: While reset is asserted and directly after it, `mem_valid`, `mem_write`, `mem_strobe`, `misalign`, `ld_valid` and `ld_data` are all 0.
- R10: A cycle with `req_valid` low produces neither `mem_valid` nor `misalign` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_is_store | input | 1 | 1 for a store, 0 for a load |
| req_size | input | 2 | 00 byte, 01 halfword, 1x word |
| req_unsigned | input | 1 | Zero-extend a byte or halfword load |
| req_base | input | 32 | Base register value |
| req_offset | input | 16 | Signed immediate offset |
| req_wdata | input | 32 | Store register value |
| rsp_valid | input | 1 | Memory read word present this cycle |
| rsp_word | input | 32 | Word read from memory |
| mem_valid | output | 1 | Aligned request issued to memory |
| mem_write | output | 1 | Issued request is a store |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_strobe | output | 4 | Byte-lane write enables, bit 3 = offset 0 |
| mem_wdata | output | 32 | Lane-copied store data |
| misalign | output | 1 | Request rejected as misaligned |
| ld_valid | output | 1 | Load result present |
| ld_data | output | 32 | Extended load result |

## Verification
The bench builds the block with its default parameters: 32-bit address and data and a 16-bit offset, which gives four byte lanes. With these values every lane offset can be reached from a small base, including both halfword positions and all three misaligned word offsets. An offset with bit 15 set tests sign extension, and the carry into the upper address bits tests the word-address path. Sign extension of a loaded byte or halfword is tested with lane values whose top bit is both set and clear.

// File: rtl/be_lsu_pkg.sv
package be_lsu_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_WALT = 2'b11
    } acc_size_e;

endpackage

// File: rtl/be_ea_calc.sv
module be_ea_calc
    import be_lsu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16,
    parameter int LANE_W = 2
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [OFF_W-1:0]  offset,
    input  acc_size_e         size,
    output logic [ADDR_W-1:0] ea,
    output logic              misaligned
);

    localparam int EXT_W = ADDR_W - OFF_W;

    assign ea = base + {{EXT_W{offset[OFF_W-1]}}, offset};

    always_comb begin
        case (size)
            SZ_BYTE: misaligned = 1'b0;
            SZ_HALF: misaligned = ea[0];
            default: misaligned = |ea[LANE_W-1:0];
        endcase
    end

endmodule

// File: rtl/be_store_lanes.sv
module be_store_lanes
    import be_lsu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANE_W = 2
) (
    input  acc_size_e          size,
    input  logic [LANE_W-1:0]  lane,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W/8-1:0] strobe,
    output logic [DATA_W-1:0]  data
);

    localparam int NUM_LANES = DATA_W / 8;

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        // strobe bit i is the lane at address offset NUM_LANES-1-i
        localparam logic [LANE_W-1:0] OFS = LANE_W'(NUM_LANES - 1 - i);
        assign strobe[i] = (size == SZ_BYTE) ? (lane == OFS) :
                           (size == SZ_HALF) ? (lane[LANE_W-1:1] == OFS[LANE_W-1:1]) :
                                               1'b1;
    end

    assign data = (size == SZ_BYTE) ? {NUM_LANES{wdata[7:0]}} :
                  (size == SZ_HALF) ? {(NUM_LANES/2){wdata[15:0]}} :
                                      wdata;

endmodule

// File: rtl/be_load_extract.sv
module be_load_extract
    import be_lsu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANE_W = 2
) (
    input  logic [DATA_W-1:0] word,
    input  acc_size_e         size,
    input  logic [LANE_W-1:0] lane,
    input  logic              is_unsigned,
    output logic [DATA_W-1:0] data
);

    localparam int NUM_LANES = DATA_W / 8;
    localparam int SH_W      = LANE_W + 3;

    logic [LANE_W-1:0] lane_rev;
    logic [SH_W-1:0]   sh_byte;
    logic [SH_W-1:0]   sh_half;
    logic [DATA_W-1:0] by_s;
    logic [DATA_W-1:0] hw_s;

    // offset 0 is the most significant lane: shift by the reversed lane index
    assign lane_rev = LANE_W'(NUM_LANES - 1) - lane;
    assign sh_byte  = {lane_rev, 3'b000};
    assign sh_half  = {lane_rev[LANE_W-1:1], 4'b0000};
    assign by_s     = word >> sh_byte;
    assign hw_s     = word >> sh_half;

    always_comb begin
        case (size)
            SZ_BYTE: data = {{(DATA_W-8){~is_unsigned & by_s[7]}}, by_s[7:0]};
            SZ_HALF: data = {{(DATA_W-16){~is_unsigned & hw_s[15]}}, hw_s[15:0]};
            default: data = word;
        endcase
    end

endmodule

// File: rtl/be_lsu_align.sv
module be_lsu_align
    import be_lsu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int OFF_W  = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_is_store,
    input  logic [1:0]           req_size,
    input  logic                 req_unsigned,
    input  logic [ADDR_W-1:0]    req_base,
    input  logic [OFF_W-1:0]     req_offset,
    input  logic [DATA_W-1:0]    req_wdata,
    input  logic                 rsp_valid,
    input  logic [DATA_W-1:0]    rsp_word,
    output logic                 mem_valid,
    output logic                 mem_write,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [DATA_W/8-1:0]  mem_strobe,
    output logic [DATA_W-1:0]    mem_wdata,
    output logic                 misalign,
    output logic                 ld_valid,
    output logic [DATA_W-1:0]    ld_data
);

    localparam int NUM_LANES = DATA_W / 8;
    localparam int LANE_W    = $clog2(NUM_LANES);

    typedef struct packed {
        logic                  mem_valid;
        logic                  mem_write;
        logic [ADDR_W-1:0]     mem_addr;
        logic [NUM_LANES-1:0]  strobe;
        logic [DATA_W-1:0]     wdata;
        logic                  misalign;
        acc_size_e             ctx_size;
        logic [LANE_W-1:0]     ctx_lane;
        logic                  ctx_uns;
        logic                  ld_valid;
        logic [DATA_W-1:0]     ld_data;
    } state_t;

    state_t st_d;
    state_t st_q;

    acc_size_e            size_in;
    logic [ADDR_W-1:0]    ea;
    logic                 mis;
    logic [NUM_LANES-1:0] lane_strb;
    logic [DATA_W-1:0]    lane_data;
    logic [DATA_W-1:0]    ext_data;

    assign size_in = acc_size_e'(req_size);

    be_ea_calc #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W),
        .LANE_W (LANE_W)
    ) u_ea (
        .base       (req_base),
        .offset     (req_offset),
        .size       (size_in),
        .ea         (ea),
        .misaligned (mis)
    );

    be_store_lanes #(
        .DATA_W (DATA_W),
        .LANE_W (LANE_W)
    ) u_st (
        .size   (size_in),
        .lane   (ea[LANE_W-1:0]),
        .wdata  (req_wdata),
        .strobe (lane_strb),
        .data   (lane_data)
    );

    be_load_extract #(
        .DATA_W (DATA_W),
        .LANE_W (LANE_W)
    ) u_ld (
        .word        (rsp_word),
        .size        (st_q.ctx_size),
        .lane        (st_q.ctx_lane),
        .is_unsigned (st_q.ctx_uns),
        .data        (ext_data)
    );

    always_comb begin
        st_d           = st_q;
        st_d.mem_valid = req_valid & ~mis;
        st_d.misalign  = req_valid & mis;
        st_d.mem_write = req_valid & ~mis & req_is_store;
        st_d.strobe    = (req_valid & ~mis & req_is_store) ? lane_strb : '0;
        if (req_valid) begin
            st_d.mem_addr = {ea[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
            st_d.wdata    = (req_is_store & ~mis) ? lane_data : '0;
        end
        if (req_valid & ~mis & ~req_is_store) begin
            st_d.ctx_size = size_in;
            st_d.ctx_lane = ea[LANE_W-1:0];
            st_d.ctx_uns  = req_unsigned;
        end
        st_d.ld_valid = rsp_valid;
        if (rsp_valid) begin
            st_d.ld_data = ext_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_valid  = st_q.mem_valid;
    assign mem_write  = st_q.mem_write;
    assign mem_addr   = st_q.mem_addr;
    assign mem_strobe = st_q.strobe;
    assign mem_wdata  = st_q.wdata;
    assign misalign   = st_q.misalign;
    assign ld_valid   = st_q.ld_valid;
    assign ld_data    = st_q.ld_data;

endmodule

// File: rtl/be_lsu_align_chk.sv
module be_lsu_align_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                rsp_valid,
    input logic                mem_valid,
    input logic                mem_write,
    input logic [ADDR_W-1:0]   mem_addr,
    input logic [DATA_W/8-1:0] mem_strobe,
    input logic                misalign,
    input logic                ld_valid
);

    localparam int NUM_LANES = DATA_W / 8;
    localparam int LANE_W    = $clog2(NUM_LANES);

    AST_ADDR_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (mem_addr[LANE_W-1:0] == '0)); // R1

    AST_STROBE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_write) |-> ($countones(mem_strobe) == 1 ||
                                      $countones(mem_strobe) == 2 ||
                                      $countones(mem_strobe) == NUM_LANES)); // R2

    AST_MISALIGN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> (!mem_valid && mem_strobe == '0)); // R4

    AST_LOAD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_write) |-> (mem_strobe == '0)); // R5

    AST_LOAD_RETURN_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> ld_valid); // R6

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!mem_valid && !misalign)); // R10

endmodule

bind be_lsu_align be_lsu_align_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .rsp_valid  (rsp_valid),
    .mem_valid  (mem_valid),
    .mem_write  (mem_write),
    .mem_addr   (mem_addr),
    .mem_strobe (mem_strobe),
    .misalign   (misalign),
    .ld_valid   (ld_valid)
);

// File: tb/be_lsu_align_bench.sv
module be_lsu_align_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_is_store = 1'b0;
    logic [1:0]  req_size = 2'b00;
    logic        req_unsigned = 1'b0;
    logic [31:0] req_base = '0;
    logic [15:0] req_offset = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid = 1'b0;
    logic [31:0] rsp_word = '0;
    logic        mem_valid;
    logic        mem_write;
    logic [31:0] mem_addr;
    logic [3:0]  mem_strobe;
    logic [31:0] mem_wdata;
    logic        misalign;
    logic        ld_valid;
    logic [31:0] ld_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    be_lsu_align u_be_lsu_align (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_is_store (req_is_store),
        .req_size     (req_size),
        .req_unsigned (req_unsigned),
        .req_base     (req_base),
        .req_offset   (req_offset),
        .req_wdata    (req_wdata),
        .rsp_valid    (rsp_valid),
        .rsp_word     (rsp_word),
        .mem_valid    (mem_valid),
        .mem_write    (mem_write),
        .mem_addr     (mem_addr),
        .mem_strobe   (mem_strobe),
        .mem_wdata    (mem_wdata),
        .misalign     (misalign),
        .ld_valid     (ld_valid),
        .ld_data      (ld_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // spec model: strobe for a store at lane offset k (bit 3 = offset 0)
    function automatic logic [3:0] model_strobe(input logic [1:0] sz, input int k);
        if (sz == 2'b00) return 4'b1000 >> k;
        if (sz == 2'b01) return (k < 2) ? 4'b1100 : 4'b0011;
        return 4'b1111;
    endfunction

    function automatic logic [31:0] model_repl(input logic [1:0] sz, input logic [31:0] v);
        if (sz == 2'b00) return {v[7:0], v[7:0], v[7:0], v[7:0]};
        if (sz == 2'b01) return {v[15:0], v[15:0]};
        return v;
    endfunction

    function automatic logic [31:0] model_load(input logic [1:0] sz, input logic uns,
                                               input int k, input logic [31:0] w);
        logic [7:0]  b;
        logic [15:0] h;
        b = w[31-8*k -: 8];
        h = w[31-8*k -: 16];
        if (sz == 2'b00) return uns ? {24'h0, b} : {{24{b[7]}}, b};
        if (sz == 2'b01) return uns ? {16'h0, h} : {{16{h[15]}}, h};
        return w;
    endfunction

    task automatic issue(input logic st, input logic [1:0] sz, input logic uns,
                         input logic [31:0] base, input logic [15:0] off,
                         input logic [31:0] wd);
        @(negedge clk);
        req_valid    = 1'b1;
        req_is_store = st;
        req_size     = sz;
        req_unsigned = uns;
        req_base     = base;
        req_offset   = off;
        req_wdata    = wd;
        @(negedge clk);
        req_valid    = 1'b0;
    endtask

    task automatic respond(input logic [31:0] w);
        @(negedge clk);
        rsp_valid = 1'b1;
        rsp_word  = w;
        @(negedge clk);
        rsp_valid = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 mem_valid in reset", {31'h0, mem_valid}, 32'h0);
        chk("R9 misalign in reset", {31'h0, misalign}, 32'h0);
        chk("R9 strobe in reset", {28'h0, mem_strobe}, 32'h0);
        chk("R9 ld_valid in reset", {31'h0, ld_valid}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 mem_write after reset", {31'h0, mem_write}, 32'h0);
        chk("R9 ld_data after reset", ld_data, 32'h0);
    endtask

    task automatic t_stores(input logic [1:0] sz, input int step);
        for (int k = 0; k < 4; k += step) begin
            issue(1'b1, sz, 1'b0, 32'h0000_1000, 16'(k), 32'hA1B2_C3D4);
            chk("R2 store valid", {30'h0, mem_valid, mem_write}, 32'h3);
            chk("R1 store addr", mem_addr, 32'h0000_1000);
            chk("R2 store strobe", {28'h0, mem_strobe}, {28'h0, model_strobe(sz, k)});
            chk("R3 store data", mem_wdata, model_repl(sz, 32'hA1B2_C3D4));
        end
    endtask

    task automatic t_neg_offset();
        // 0x0001_0002 + (-6) = 0x0000_FFFC
        issue(1'b1, 2'b00, 1'b0, 32'h0001_0002, 16'hFFFA, 32'h0000_005A);
        chk("R1 negative offset addr", mem_addr, 32'h0000_FFFC);
        chk("R2 negative offset strobe", {28'h0, mem_strobe}, 32'h8);
        // 0x0000_FFFE + 0x7FFF = 0x0001_7FFD, byte at offset 1
        issue(1'b1, 2'b00, 1'b0, 32'h0000_FFFE, 16'h7FFF, 32'h0000_005A);
        chk("R1 carry addr", mem_addr, 32'h0001_7FFC);
        chk("R2 carry strobe", {28'h0, mem_strobe}, 32'h4);
    endtask

    task automatic t_misalign();
        for (int k = 1; k < 4; k++) begin
            issue(1'b1, 2'b10, 1'b0, 32'h0000_2000, 16'(k), 32'hFFFF_FFFF);
            chk("R4 word misalign flag", {31'h0, misalign}, 32'h1);
            chk("R4 word misalign no valid", {31'h0, mem_valid}, 32'h0);
            chk("R4 word misalign no strobe", {28'h0, mem_strobe}, 32'h0);
        end
        issue(1'b1, 2'b01, 1'b0, 32'h0000_2000, 16'h0003, 32'hFFFF_FFFF);
        chk("R4 half misalign flag", {31'h0, misalign}, 32'h1);
        chk("R4 half misalign no strobe", {28'h0, mem_strobe}, 32'h0);
        @(negedge clk);
        chk("R4 flag lasts one cycle", {31'h0, misalign}, 32'h0);
        chk("R10 idle no valid", {31'h0, mem_valid}, 32'h0);
    endtask

    task automatic t_loads(input logic [1:0] sz, input logic uns, input int step,
                           input logic [31:0] w);
        for (int k = 0; k < 4; k += step) begin
            issue(1'b0, sz, uns, 32'h0000_3000, 16'(k), 32'h0);
            chk("R5 load valid no write", {30'h0, mem_valid, mem_write}, 32'h2);
            chk("R5 load no strobe", {28'h0, mem_strobe}, 32'h0);
            respond(w);
            chk("R6 load ld_valid", {31'h0, ld_valid}, 32'h1);
            chk(uns ? "R7 load zero-extend" : "R7 load sign-extend", ld_data,
                model_load(sz, uns, k, w));
        end
    endtask

    task automatic t_context_hold();
        issue(1'b0, 2'b00, 1'b0, 32'h0000_4000, 16'h0002, 32'h0);
        issue(1'b1, 2'b10, 1'b1, 32'h0000_4000, 16'h0000, 32'h1234_5678);
        issue(1'b0, 2'b10, 1'b1, 32'h0000_4000, 16'h0001, 32'h0);
        chk("R8 misaligned load flagged", {31'h0, misalign}, 32'h1);
        respond(32'h1122_9344);
        chk("R8 context kept from aligned load", ld_data, 32'hFFFF_FF93);
        @(negedge clk);
        chk("R6 ld_valid drops", {31'h0, ld_valid}, 32'h0);
    endtask

    initial begin
        t_reset();
        t_stores(2'b00, 1);
        t_stores(2'b01, 2);
        t_stores(2'b10, 4);
        t_stores(2'b11, 4);
        t_neg_offset();
        t_misalign();
        t_loads(2'b00, 1'b0, 1, 32'h80F1_7F02);
        t_loads(2'b00, 1'b1, 1, 32'h80F1_7F02);
        t_loads(2'b01, 1'b0, 2, 32'h8001_7FFF);
        t_loads(2'b01, 1'b1, 2, 32'hC001_9FFF);
        t_loads(2'b10, 1'b0, 4, 32'hDEAD_BEEF);
        t_context_hold();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule